// File: doc/BRIEF.md
# Single-Source Audio Routing Matrix

This block is a crosspoint that routes audio samples from a set of sources to a set of destinations. Each destination is driven by exactly one source. A single source may drive any number of destinations at the same time. A routing table holds one source index per destination. A multiplexer then forwards, for every destination, the sample word of the source it is mapped to. Source index 0 means silence, and every destination starts there after reset.

Software programs the table through four 6-bit registers: destination high, destination low, source high and source low. Routing codes are 11 bits wide, and only bits 10:8 and 4:0 carry meaning. The high register takes the code shifted right by eight. The low register takes code bits 4:0. A route is programmed in this order:

1. Select the destination.
2. Load the source high half.
3. Write the source low half. This write commits the route.

To read a route back, select the destination and then read the two source registers. Those registers always show the stored route of the selected destination.

Top module: `route_matrix`

## Requirements
- R1: After reset, every destination output is zero, the two selection registers read 0, and both source registers read 0 for any selected destination.
- R2: Register addresses are 0 = destination high, 1 = destination low, 2 = source high, 3 = source low. An index is high*32 + low, where the high half is 3 bits and the low half is 5 bits. Reading address 0 or 1 returns the 6-bit value last written there.
- R3: A write to source low stores {latched source high, written low} as the route of the selected destination. The new route is visible from the next clock edge.
- R4: A write to source high alone leaves the routing table and every destination output unchanged.
- R5: Reading address 2 returns the stored source index bits 7:5 and reading address 3 returns bits 4:0, for the destination currently selected.
- R6: Any number of destinations can be mapped to the same source, and each of them carries that source's sample.
- R7: Writing a new route for a destination replaces its previous source. Other destinations keep their routes.
- R8: A commit is rejected, leaving the table unchanged, when any of these registers has a bit set outside its valid half: destination high or source high above 7, destination low above 31, or the source low write data above 31.
- R9: A commit is rejected when the destination index is not below DST_COUNT or the source index is not below SRC_COUNT. While an out-of-range destination is selected, both source registers read 0.
- R10: A destination mapped to source 0 outputs zero, whatever sample is present on input slot 0.
- R11: Each destination output equals the sample of its mapped source combinationally, so a change on a source input appears on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select for reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 6 | Register write data |
| regRdData | output | 6 | Contents of the addressed register (combinational) |
| srcSamples | input | SRC_COUNT*SAMPLE_W | Packed source samples, slot s at bits s*SAMPLE_W upward |
| dstSamples | output | DST_COUNT*SAMPLE_W | Packed destination samples, slot d at bits d*SAMPLE_W upward |

## Verification
Routes are exercised with a source whose high half is non-zero (33), so a lost high half shows up as a wrong sample and a wrong readback. One source is mapped to three destinations at once, and its input sample is then changed to separate true fan-out from a stale copy. Illegal codes are chosen so that truncating them to the valid bits would alias onto an existing route: destination high 8, source high 8 and source low 0x21. A design that masks instead of rejecting therefore visibly overwrites that route. Index 36 for a destination and 40 for a source probe the range limits, and a route to source 0 with a non-zero slot-0 input separates silence from plain forwarding.

// File: rtl/route_matrix_pkg.sv
package route_matrix_pkg;
  localparam int REG_W = 6;
  localparam int HI_W = 3;
  localparam int LO_W = 5;
  localparam int IDX_W = HI_W + LO_W;

  typedef enum logic [1:0] {
    REG_DST_HI = 2'd0,
    REG_DST_LO = 2'd1,
    REG_SRC_HI = 2'd2,
    REG_SRC_LO = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             commit;
    logic [IDX_W-1:0] dstIdx;
    logic [IDX_W-1:0] srcIdx;
    logic             selValid;
    logic [IDX_W-1:0] selIdx;
  } routeCmd_t;
endpackage

// File: rtl/route_ctrl.sv
module route_ctrl
  import route_matrix_pkg::*;
#(
  parameter int DST_COUNT = 36,
  parameter int SRC_COUNT = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic [IDX_W-1:0] selEntry,
  output routeCmd_t        cmd,
  output logic [REG_W-1:0] regRdData
);
  localparam logic [IDX_W-1:0] DST_LIMIT = IDX_W'(DST_COUNT);
  localparam logic [IDX_W-1:0] SRC_LIMIT = IDX_W'(SRC_COUNT);

  regSel_e regSel;
  logic [REG_W-1:0] dstHiQ, dstLoQ, srcHiQ;
  logic [IDX_W-1:0] dstIdx, srcIdx;
  logic dstCodeOk, srcCodeOk, dstInRange, srcInRange, wrSrcLo;

  assign regSel = regSel_e'(regAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstHiQ <= '0;
      dstLoQ <= '0;
      srcHiQ <= '0;
    end else if (regWrEn) begin
      case (regSel)
        REG_DST_HI: dstHiQ <= regWrData;
        REG_DST_LO: dstLoQ <= regWrData;
        REG_SRC_HI: srcHiQ <= regWrData;
        default: ;
      endcase
    end
  end

  assign dstIdx = {dstHiQ[HI_W-1:0], dstLoQ[LO_W-1:0]};
  assign srcIdx = {srcHiQ[HI_W-1:0], regWrData[LO_W-1:0]};
  assign dstCodeOk = (dstHiQ[REG_W-1:HI_W] == '0) && (dstLoQ[REG_W-1:LO_W] == '0);
  assign srcCodeOk = (srcHiQ[REG_W-1:HI_W] == '0) && (regWrData[REG_W-1:LO_W] == '0);
  assign dstInRange = dstIdx < DST_LIMIT;
  assign srcInRange = srcIdx < SRC_LIMIT;
  assign wrSrcLo = regWrEn && (regSel == REG_SRC_LO);

  always_comb begin
    cmd.commit = wrSrcLo && dstCodeOk && srcCodeOk && dstInRange && srcInRange;
    cmd.dstIdx = dstIdx;
    cmd.srcIdx = srcIdx;
    cmd.selValid = dstCodeOk && dstInRange;
    cmd.selIdx = dstIdx;
  end

  always_comb begin
    case (regSel)
      REG_DST_HI: regRdData = dstHiQ;
      REG_DST_LO: regRdData = dstLoQ;
      REG_SRC_HI: regRdData = REG_W'(selEntry[IDX_W-1:LO_W]);
      default:    regRdData = REG_W'(selEntry[LO_W-1:0]);
    endcase
  end

  // R8: a source-low write carrying a bit above the low half never commits
  assert_reject_lo_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd3 && regWrData[REG_W-1]) |-> !cmd.commit);

  // R8: an out-of-mask destination high register blocks every commit
  assert_reject_dsthi_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dstHiQ > REG_W'(7)) |-> !cmd.commit);
endmodule

// File: rtl/route_table.sv
module route_table
  import route_matrix_pkg::*;
#(
  parameter int DST_COUNT = 36,
  parameter int SRC_COUNT = 40,
  parameter int SAMPLE_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  routeCmd_t                     cmd,
  input  logic [SRC_COUNT*SAMPLE_W-1:0] srcSamples,
  output logic [DST_COUNT*SAMPLE_W-1:0] dstSamples,
  output logic [IDX_W-1:0]              selEntry
);
  localparam int DST_W = (DST_COUNT > 1) ? $clog2(DST_COUNT) : 1;
  localparam int SRC_W = (SRC_COUNT > 1) ? $clog2(SRC_COUNT) : 1;
  localparam logic [SRC_W-1:0] SRC_LIMIT = SRC_W'(SRC_COUNT);

  logic [SRC_W-1:0] mapQ [DST_COUNT];
  logic [DST_COUNT*SRC_W-1:0] mapFlat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int d = 0; d < DST_COUNT; d++) mapQ[d] <= '0;
    end else if (cmd.commit) begin
      mapQ[cmd.dstIdx[DST_W-1:0]] <= cmd.srcIdx[SRC_W-1:0];
    end
  end

  assign selEntry = cmd.selValid ? IDX_W'(mapQ[cmd.selIdx[DST_W-1:0]]) : '0;

  for (genvar d = 0; d < DST_COUNT; d++) begin : g_dst
    logic [SRC_W-1:0] pick;
    assign pick = mapQ[d];
    assign mapFlat[d*SRC_W +: SRC_W] = pick;

    always_comb begin
      if (pick == '0 || pick >= SRC_LIMIT) dstSamples[d*SAMPLE_W +: SAMPLE_W] = '0;
      else dstSamples[d*SAMPLE_W +: SAMPLE_W] = srcSamples[pick*SAMPLE_W +: SAMPLE_W];
    end

    // R10: a destination routed to source 0 is silent
    assert_silence_R10: assert property (@(posedge clk) disable iff (!rstN)
      (mapQ[d] == '0) |-> (dstSamples[d*SAMPLE_W +: SAMPLE_W] == '0));
  end

  // R4: without a commit strobe the table keeps its contents
  assert_table_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.commit |=> $stable(mapFlat));

  // R3: a commit lands in the selected destination on the next edge
  assert_commit_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> (mapQ[$past(cmd.dstIdx[DST_W-1:0])] == $past(cmd.srcIdx[SRC_W-1:0])));
endmodule

// File: rtl/route_matrix.sv
module route_matrix
  import route_matrix_pkg::*;
#(
  parameter int DST_COUNT = 36,
  parameter int SRC_COUNT = 40,
  parameter int SAMPLE_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    regAddr,
  input  logic                          regWrEn,
  input  logic [5:0]                    regWrData,
  output logic [5:0]                    regRdData,
  input  logic [SRC_COUNT*SAMPLE_W-1:0] srcSamples,
  output logic [DST_COUNT*SAMPLE_W-1:0] dstSamples
);
  routeCmd_t cmd;
  logic [IDX_W-1:0] selEntry;

  route_ctrl #(.DST_COUNT(DST_COUNT), .SRC_COUNT(SRC_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .selEntry(selEntry), .cmd(cmd), .regRdData(regRdData)
  );

  route_table #(.DST_COUNT(DST_COUNT), .SRC_COUNT(SRC_COUNT), .SAMPLE_W(SAMPLE_W)) u_table (
    .clk(clk), .rstN(rstN), .cmd(cmd), .srcSamples(srcSamples),
    .dstSamples(dstSamples), .selEntry(selEntry)
  );
endmodule

// File: tb/tb_route_matrix.sv
module tb_route_matrix;
  localparam int CLK_PERIOD = 10;
  localparam int DSTN = 36;
  localparam int SRCN = 40;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [5:0] regWrData = '0;
  logic [5:0] regRdData;
  logic [SRCN*SW-1:0] srcSamples;
  logic [DSTN*SW-1:0] dstSamples;

  int checks = 0;
  int errors = 0;

  route_matrix #(.DST_COUNT(DSTN), .SRC_COUNT(SRCN), .SAMPLE_W(SW)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .srcSamples(srcSamples), .dstSamples(dstSamples)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [SW-1:0] srcVal(int s);
    return 16'h5000 + 16'(s);
  endfunction

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(int a, int v);
    @(negedge clk);
    regAddr = 2'(a);
    regWrData = 6'(v);
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(int a, output int v);
    @(negedge clk);
    regAddr = 2'(a);
    #1 v = int'(regRdData);
  endtask

  task automatic mapRoute(int d, int s);
    regWrite(0, d >> 5);
    regWrite(1, d & 31);
    regWrite(2, s >> 5);
    regWrite(3, s & 31);
  endtask

  task automatic readRoute(int d, output int s);
    int hi, lo;
    regWrite(0, d >> 5);
    regWrite(1, d & 31);
    regRead(2, hi);
    regRead(3, lo);
    s = (hi << 8) | lo;
  endtask

  function automatic int outOf(int d);
    return int'(dstSamples[d*SW +: SW]);
  endfunction

  task automatic testReset();
    int v;
    bit allZero = 1'b1;
    for (int d = 0; d < DSTN; d++) if (outOf(d) != 0) allZero = 1'b0;
    checkEq("R1 outputs zero", int'(allZero), 1);
    regRead(0, v); checkEq("R1 dst high", v, 0);
    regRead(1, v); checkEq("R1 dst low", v, 0);
    readRoute(20, v); checkEq("R1 route readback", v, 0);
  endtask

  task automatic testBasic();
    int v;
    mapRoute(3, 33);
    regRead(0, v); checkEq("R2 dst high readback", v, 0);
    regRead(1, v); checkEq("R2 dst low readback", v, 3);
    regRead(2, v); checkEq("R5 src high readback", v, 1);
    regRead(3, v); checkEq("R5 src low readback", v, 1);
    checkEq("R3 route applied", outOf(3), int'(srcVal(33)));
    checkEq("R11 other dst silent", outOf(4), 0);
  endtask

  task automatic testPendingHigh();
    int v;
    regWrite(0, 0);
    regWrite(1, 3);
    regWrite(2, 0);
    readRoute(3, v);
    checkEq("R4 table after high-only write", v, (1 << 8) | 1);
    checkEq("R4 output after high-only write", outOf(3), int'(srcVal(33)));
  endtask

  task automatic testFanout();
    mapRoute(0, 7);
    mapRoute(5, 7);
    mapRoute(35, 7);
    checkEq("R6 fanout dst0", outOf(0), int'(srcVal(7)));
    checkEq("R6 fanout dst5", outOf(5), int'(srcVal(7)));
    checkEq("R6 fanout dst35", outOf(35), int'(srcVal(7)));
    @(negedge clk);
    srcSamples[7*SW +: SW] = 16'h1234;
    #1;
    checkEq("R11 dst0 follows input", outOf(0), 16'h1234);
    checkEq("R11 dst35 follows input", outOf(35), 16'h1234);
    srcSamples[7*SW +: SW] = srcVal(7);
  endtask

  task automatic testReplace();
    int v;
    mapRoute(5, 39);
    checkEq("R7 replaced output", outOf(5), int'(srcVal(39)));
    readRoute(5, v);
    checkEq("R7 replaced readback", v, (1 << 8) | 7);
    checkEq("R7 neighbour kept", outOf(0), int'(srcVal(7)));
  endtask

  task automatic testReject();
    int v;
    regWrite(0, 8); regWrite(1, 3); regWrite(2, 0); regWrite(3, 4);
    readRoute(3, v);
    checkEq("R8 dst high 8 rejected", v, (1 << 8) | 1);
    regWrite(2, 8); regWrite(3, 2);
    readRoute(3, v);
    checkEq("R8 src high 8 rejected", v, (1 << 8) | 1);
    regWrite(2, 0); regWrite(3, 6'h21);
    readRoute(3, v);
    checkEq("R8 src low 0x21 rejected", v, (1 << 8) | 1);
    regWrite(0, 0); regWrite(1, 6'h23); regWrite(2, 0); regWrite(3, 4);
    readRoute(3, v);
    checkEq("R8 dst low 0x23 rejected", v, (1 << 8) | 1);
    checkEq("R8 output kept", outOf(3), int'(srcVal(33)));
  endtask

  task automatic testRange();
    int v;
    mapRoute(36, 5);
    readRoute(36, v);
    checkEq("R9 out-of-range dst reads 0", v, 0);
    readRoute(4, v);
    checkEq("R9 dst4 untouched", v, 0);
    mapRoute(6, 40);
    readRoute(6, v);
    checkEq("R9 src 40 rejected", v, 0);
    checkEq("R9 dst6 silent", outOf(6), 0);
  endtask

  task automatic testSilence();
    mapRoute(2, 9);
    checkEq("R10 routed before silence", outOf(2), int'(srcVal(9)));
    mapRoute(2, 0);
    checkEq("R10 source 0 silent", outOf(2), 0);
  endtask

  initial begin
    for (int s = 0; s < SRCN; s++) srcSamples[s*SW +: SW] = srcVal(s);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testBasic();
    testPendingHigh();
    testFanout();
    testReplace();
    testReject();
    testRange();
    testSilence();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule